// File: doc/BRIEF.md
# Dual 16-bit Timer/Counter

This block holds two 16-bit count channels. Software reaches them through a small register port: a control byte, a mode byte, and the low and high count bytes of each channel. Each channel runs in one of two functions. In the timer function it counts machine cycles. In the counter function it counts falling edges on its own external pin. A prescaler divides the input clock by `DIV` (12 by default) to form a one-cycle machine-cycle strobe, and all counting happens on that strobe.

Each channel has four count layouts:

- a 13-bit count made of the high byte and the low five bits of the low byte;
- a plain 16-bit count;
- an 8-bit low-byte count that reloads from the high byte when it overflows;
- a split layout.

In the split layout, channel 0 becomes two independent 8-bit counters. Channel 1 placed in the split layout freezes.

An overflow sets that channel's flag. The flag drives an interrupt output directly. An acknowledge input clears the flag.

In counter function, a per-channel edge state machine samples the pin on each strobe. It has three states:

- `EDGE_WAIT_HIGH`: no high sample seen yet.
- `EDGE_ARMED`: the last sample was high.
- `EDGE_PENDING`: a high-then-low pair was seen.

Its transitions, all taken on a strobe:

- `WAIT_HIGH→ARMED` on a high sample.
- `ARMED→PENDING` on a low sample.
- `ARMED` stays `ARMED` on a high sample.
- `PENDING→ARMED` on a high sample, and `PENDING→WAIT_HIGH` on a low sample. Both emit one count pulse.

A detected edge therefore shows in the count one machine cycle later.

Top module: `tc_pair`

## Requirements
- R1: After reset every register reads 0x00 and both `irq` bits are 0.
- R2: Register addresses are: 0 = control, 1 = mode, 2/3 = channel 0 low/high byte, 4/5 = channel 1 low/high byte. Reads are combinational and writes take effect at the clock edge. Control bits from 7 down to 0 are: flag 1, run 1, flag 0, run 0, then four plain storage bits. The mode byte's upper nibble configures channel 1 and its lower nibble channel 0. Each nibble holds, from bit 3 to bit 0: gate enable, counter select (1 = external edges), and a 2-bit layout code.
- R3: In timer function a running channel advances by exactly one per `DIV` clocks. The first strobe after reset falls on the `DIV`-th clock edge.
- R4: A channel counts only when its run bit is 1 and either its gate enable is 0 or its `gate_in` bit is 1.
- R5: In counter function the pin is sampled once per machine cycle. A high sample followed by a low sample adds one, and the new value appears one machine cycle after the low sample. A low pulse that falls between two samples is not counted.
- R6: Layout code 0 counts 13 bits ({high byte, low[4:0]}), leaves low[7:5] untouched, and overflows from all ones to zero.
- R7: Layout code 1 counts 16 bits and overflows from 0xFFFF to 0x0000.
- R8: Layout code 2 counts in the low byte only. On overflow it loads the low byte from the high byte.
- R9: With channel 0 on layout code 3, its low byte counts under run 0 and sets flag 0. Its high byte counts machine cycles under run 1 and sets flag 1.
- R10: Channel 1 on layout code 3 holds both of its count bytes.
- R11: An overflow sets its flag, and `irq[n]` equals flag n. `irq_ack[n]` clears flag n. An overflow in the same cycle as an acknowledge leaves the flag set, and a control write sets or clears a flag directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| t_in | input | 2 | External count pins, bit n for channel n |
| gate_in | input | 2 | External gate pins, bit n for channel n |
| irq_ack | input | 2 | Interrupt acknowledge, clears flag n |
| irq | output | 2 | Overflow interrupt, one per channel |

## Verification
The timer function is driven from preset values placed just below each layout's overflow point, with run lengths of a few machine cycles. The final count, the reload value and the flags separate the 13-bit, 16-bit, reload and split layouts from each other and from a held channel. The counter function gets three pin patterns:

- a single held-low step, read both one and two machine cycles after the edge, which exposes the one-cycle latency;
- a short low glitch placed between samples, which must not count;
- a square wave of one machine cycle high and one low, which must count every fall.

Gate-low versus gate-high runs, and an acknowledge that lands on the overflow cycle, separate the enable and flag-priority rules.

// File: rtl/tc_pair_pkg.sv
package tc_pair_pkg;
    localparam int BYTE_W   = 8;
    localparam int NARROW_W = 5;   // low-byte bits used by the 13-bit layout

    typedef enum logic [1:0] {
        MODE_13     = 2'd0,
        MODE_16     = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_SPLIT  = 2'd3
    } tc_mode_e;

    typedef struct packed {
        logic     gate;
        logic     is_cnt;
        tc_mode_e mode;
    } tc_cfg_t;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_MODE = 3'd1,
        A_LO0  = 3'd2,
        A_HI0  = 3'd3,
        A_LO1  = 3'd4,
        A_HI1  = 3'd5
    } tc_addr_e;

    typedef enum logic [1:0] {
        EDGE_WAIT_HIGH = 2'd0,
        EDGE_ARMED     = 2'd1,
        EDGE_PENDING   = 2'd2
    } edge_st_e;
endpackage

// File: rtl/tc_prescale.sv
module tc_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic strobe
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] ps;

    assign strobe = (ps == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || strobe) ps <= '0;
        else               ps <= ps + 1'b1;
    end

    // R3: strobe is a single-cycle pulse
    p_strobe_gap_r3: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
endmodule

// File: rtl/tc_edge.sv
module tc_edge
    import tc_pair_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic pin,
    output logic fall_cnt
);
    edge_st_e state, state_n;

    always_ff @(posedge clk) begin
        if (rst) state <= EDGE_WAIT_HIGH;
        else     state <= state_n;
    end

    always_comb begin
        state_n  = state;
        fall_cnt = 1'b0;
        if (strobe) begin
            unique case (state)
                EDGE_WAIT_HIGH: if (pin) state_n = EDGE_ARMED;
                EDGE_ARMED:     if (!pin) state_n = EDGE_PENDING;
                EDGE_PENDING: begin
                    fall_cnt = 1'b1;
                    state_n  = pin ? EDGE_ARMED : EDGE_WAIT_HIGH;
                end
                default:        state_n = EDGE_WAIT_HIGH;
            endcase
        end
    end

    // R5: one count per detected fall, never on consecutive cycles
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        fall_cnt |=> !fall_cnt);
endmodule

// File: rtl/tc_chan.sv
module tc_chan
    import tc_pair_pkg::*;
#(
    parameter bit SPLIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  tc_cfg_t           cfg,
    input  logic              run,
    input  logic              ext_cnt,
    input  logic              hi_run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] tl,
    output logic [BYTE_W-1:0] th,
    output logic              ovf_lo,
    output logic              ovf_hi
);
    localparam int WIDE_W = BYTE_W + NARROW_W;

    logic [BYTE_W-1:0] tl_n, th_n;
    logic              tick, hi_tick;

    assign tick    = run & (cfg.is_cnt ? ext_cnt : strobe);
    assign hi_tick = SPLIT && (cfg.mode == MODE_SPLIT) && hi_run && strobe;

    always_comb begin
        tl_n   = tl;
        th_n   = th;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        if (tick) begin
            unique case (cfg.mode)
                MODE_13: begin
                    {th_n, tl_n[NARROW_W-1:0]} = {th, tl[NARROW_W-1:0]} + WIDE_W'(1);
                    ovf_lo = &{th, tl[NARROW_W-1:0]};
                end
                MODE_16: begin
                    {th_n, tl_n} = {th, tl} + (2*BYTE_W)'(1);
                    ovf_lo = &{th, tl};
                end
                MODE_RELOAD: begin
                    ovf_lo = &tl;
                    tl_n   = (&tl) ? th : tl + 1'b1;
                end
                MODE_SPLIT: if (SPLIT) begin
                    tl_n   = tl + 1'b1;
                    ovf_lo = &tl;
                end
            endcase
        end
        if (hi_tick) begin
            th_n   = th + 1'b1;
            ovf_hi = &th;
        end
        if (wr_lo) tl_n = wr_data;
        if (wr_hi) th_n = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tl <= '0;
            th <= '0;
        end else begin
            tl <= tl_n;
            th <= th_n;
        end
    end

    // R7: 16-bit overflow lands on zero
    p_wrap16_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_16 && ovf_lo && !wr_lo && !wr_hi) |=> (tl == '0 && th == '0));
    // R8: reload layout copies the high byte into the low byte on overflow
    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_RELOAD && ovf_lo && !wr_lo) |=> (tl == $past(th)));
endmodule

// File: rtl/tc_pair.sv
module tc_pair
    import tc_pair_pkg::*;
#(
    parameter int DIV = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic [1:0] t_in,
    input  logic [1:0] gate_in,
    input  logic [1:0] irq_ack,
    output logic [1:0] irq
);
    localparam int NCH    = 2;
    localparam int B_TF1  = 7;
    localparam int B_TR1  = 6;
    localparam int B_TF0  = 5;
    localparam int B_TR0  = 4;

    logic [BYTE_W-1:0]          tcon, tcon_n, tmod;
    logic                       strobe;
    logic [NCH-1:0]             fall, run, ovf_lo, ovf_hi, tr;
    logic [NCH-1:0][BYTE_W-1:0] tl, th;
    tc_cfg_t                    cfg [NCH];
    logic                       wr_ctrl;

    assign cfg[0]  = tc_cfg_t'(tmod[3:0]);
    assign cfg[1]  = tc_cfg_t'(tmod[7:4]);
    assign tr      = {tcon[B_TR1], tcon[B_TR0]};
    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign irq     = {tcon[B_TF1], tcon[B_TF0]};

    tc_prescale #(.DIV(DIV)) u_ps (.clk(clk), .rst(rst), .strobe(strobe));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign run[g] = tr[g] & (~cfg[g].gate | gate_in[g]);

        tc_edge u_edge (
            .clk(clk), .rst(rst), .strobe(strobe),
            .pin(t_in[g]), .fall_cnt(fall[g])
        );

        tc_chan #(.SPLIT(g == 0)) u_chan (
            .clk(clk), .rst(rst), .strobe(strobe), .cfg(cfg[g]),
            .run(run[g]), .ext_cnt(fall[g]), .hi_run(tcon[B_TR1]),
            .wr_lo(wr_en && addr == 3'(A_LO0 + 2*g)),
            .wr_hi(wr_en && addr == 3'(A_HI0 + 2*g)),
            .wr_data(wr_data), .tl(tl[g]), .th(th[g]),
            .ovf_lo(ovf_lo[g]), .ovf_hi(ovf_hi[g])
        );
    end

    always_comb begin
        tcon_n = tcon;
        if (wr_ctrl) begin
            tcon_n = wr_data;
        end else begin
            if (irq_ack[0]) tcon_n[B_TF0] = 1'b0;
            if (irq_ack[1]) tcon_n[B_TF1] = 1'b0;
        end
        if (ovf_lo[0])              tcon_n[B_TF0] = 1'b1;
        if (ovf_lo[1] || (|ovf_hi)) tcon_n[B_TF1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcon <= '0;
            tmod <= '0;
        end else begin
            tcon <= tcon_n;
            if (wr_en && addr == A_MODE) tmod <= wr_data;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rd_data = tcon;
            A_MODE:  rd_data = tmod;
            A_LO0:   rd_data = tl[0];
            A_HI0:   rd_data = th[0];
            A_LO1:   rd_data = tl[1];
            A_HI1:   rd_data = th[1];
            default: rd_data = '0;
        endcase
    end

    // R11: overflow sets flag 1 on the next edge
    p_tf1_set_r11: assert property (@(posedge clk) disable iff (rst)
        (ovf_lo[1] || ovf_hi[0]) |=> irq[1]);
    // R11: a lone acknowledge clears flag 0
    p_ack_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_ack[0] && !ovf_lo[0] && !wr_ctrl) |=> !irq[0]);
    // R10: channel 1 in split layout holds its count
    p_split_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg[1].mode == MODE_SPLIT && !(wr_en && (addr == A_LO1 || addr == A_HI1)))
        |=> ($stable(tl[1]) && $stable(th[1])));
endmodule

// File: tb/tc_pair_test.sv
module tc_pair_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] t_in = 2'b11;
    logic [1:0] gate_in = 2'b00;
    logic [1:0] irq_ack = 2'b00;
    logic [1:0] irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    tc_pair uut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // {ch, mode, start ctrl, lo, hi, mcycles, exp lo, exp hi, exp flags}
    localparam logic [71:0] VEC [0:9] = '{
        72'h00_01_10_34_12_07_3B_12_00,   // R3 plain run
        72'h00_01_10_FD_FF_05_02_00_20,   // R7 wrap
        72'h00_00_10_FE_FF_03_E1_00_20,   // R6 13-bit wrap
        72'h00_02_10_FE_FD_04_FF_FD_20,   // R8 reload
        72'h01_10_40_FE_FF_03_01_00_80,   // R7 channel 1
        72'h01_20_40_FF_80_02_81_80_80,   // R8 channel 1
        72'h00_03_50_FE_FE_03_01_01_A0,   // R9 split both halves
        72'h01_30_40_05_06_04_05_06_00,   // R10 channel 1 frozen
        72'h00_01_00_11_22_03_11_22_00,   // R4 not running
        72'h00_03_40_10_20_02_10_22_00    // R9 only high half runs
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R3";
            1, 4: return "R7";
            2: return "R6";
            3, 5: return "R8";
            6, 9: return "R9";
            7: return "R10";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic align();
        do @(negedge clk); while (cyc % 12 != 0);
    endtask

    task automatic wait_mc(input int n);
        repeat (12 * n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        wr(3'd0, 8'h00);
        for (int a = 2; a < 6; a++) wr(3'(a), 8'h00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1", v, 8'h00);
        end
        chk("R1 irq", {6'd0, irq}, 8'h00);

        // R2 storage bits and mode byte
        @(negedge clk);
        wr(3'd0, 8'h0F);
        @(negedge clk); rd(3'd0, v); chk("R2 ctrl", v, 8'h0F);
        wr(3'd1, 8'hA5);
        @(negedge clk); rd(3'd1, v); chk("R2 mode", v, 8'hA5);
        wr(3'd1, 8'h00);

        // table walk
        for (int i = 0; i < 10; i++) begin
            logic [71:0] e;
            logic [2:0]  lo_a;
            e = VEC[i];
            lo_a = 3'(2 + 2 * e[64]);
            @(negedge clk);
            clear_all();
            wr(3'd1, e[63:56]);
            wr(lo_a, e[47:40]);
            wr(lo_a + 3'd1, e[39:32]);
            align();
            wr(3'd0, e[55:48]);
            repeat (12 * int'(e[31:24]) - 1) @(posedge clk);
            @(negedge clk);
            rd(lo_a, v);        chk(vtag(i), v, e[23:16]);
            rd(lo_a + 3'd1, v); chk(vtag(i), v, e[15:8]);
            rd(3'd0, v);        chk(vtag(i), v & 8'hA0, e[7:0]);
        end

        // R11 overflow coincides with acknowledge: flag stays set
        @(negedge clk);
        clear_all();
        wr(3'd1, 8'h01);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        align();
        wr(3'd0, 8'h10);
        do @(negedge clk); while (cyc % 12 != 11);
        irq_ack = 2'b01;
        @(negedge clk) irq_ack = 2'b00;
        chk("R11 set wins", {6'd0, irq}, 8'h01);
        irq_ack = 2'b01;
        @(negedge clk) irq_ack = 2'b00;
        chk("R11 ack clears", {6'd0, irq}, 8'h00);
        wr(3'd0, 8'hA0);
        @(negedge clk);
        chk("R11 write sets", {6'd0, irq}, 8'h03);

        // R4 gate input
        clear_all();
        wr(3'd1, 8'h09);
        gate_in = 2'b00;
        align();
        wr(3'd0, 8'h10);
        repeat (59) @(posedge clk);
        @(negedge clk);
        rd(3'd2, v); chk("R4 gate low", v, 8'h00);
        gate_in = 2'b01;
        wait_mc(5);
        rd(3'd2, v); chk("R4 gate high", v, 8'h05);
        gate_in = 2'b00;

        // R5 counter function
        @(negedge clk);
        clear_all();
        wr(3'd1, 8'h05);
        t_in = 2'b11;
        align();
        wr(3'd0, 8'h10);
        align();
        t_in[0] = 1'b0;
        wait_mc(1);
        rd(3'd2, v); chk("R5 latency", v, 8'h00);
        wait_mc(1);
        rd(3'd2, v); chk("R5 counted", v, 8'h01);
        t_in[0] = 1'b1;
        wait_mc(1);
        repeat (2) @(negedge clk);
        t_in[0] = 1'b0;
        repeat (3) @(negedge clk);
        t_in[0] = 1'b1;
        align();
        wait_mc(3);
        rd(3'd2, v); chk("R5 glitch", v, 8'h01);
        for (int k = 0; k < 4; k++) begin
            t_in[0] = 1'b0;
            wait_mc(1);
            t_in[0] = 1'b1;
            wait_mc(1);
        end
        wait_mc(1);
        rd(3'd2, v); chk("R5 square wave", v, 8'h05);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule